// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block owns every refresh cycle of a two-bank asynchronous DRAM array. After reset it waits out the power-up settling time. It then runs a fixed number of initialization refresh cycles. After that it keeps a steady stream of CAS-before-RAS refreshes going, one owed per refresh interval.

It never takes the strobes by force. When work is owed it raises `ref_req` and waits for `ref_gnt` from the access controller. A grant means the controller has closed its open row and handed over the strobe pins. While it holds the strobes, `seq_drive` is high, `we_n` is high, and both banks see identical RAS and CAS waveforms.

Refreshes owed while the grant is withheld are counted, up to a ceiling. They are issued back to back for as long as the grant stays high. `ready` tells the controller when normal accesses may begin.

All timing is given in clock cycles through parameters. The defaults assume a 100 MHz clock: 200 µs start-up, a 15.6 µs interval, 60 ns RAS low and 40 ns precharge.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ref_req`, `ready` and `seq_drive` are 0 and every `ras_n`/`cas_n` bit is 1.
- R2: `ref_req` stays 0 for the first STARTUP_CYC clock edges after reset release. It is 1 after edge STARTUP_CYC+1.
- R3: `ready` rises on the clock edge that ends the INIT_REFRESHES-th refresh cycle, counted as RAS falling edges. Once high, it stays high until reset.
- R4: Once raised, `ref_req` holds until `ref_gnt` is seen. No strobe moves and `seq_drive` stays 0 until the grant is seen.
- R5: In every refresh, CAS (low = active) falls exactly CAS_LEAD_CYC cycles before RAS falls.
- R6: RAS stays low for exactly RAS_LOW_CYC cycles, and CAS returns high on the same edge that RAS does.
- R7: Between a RAS rise and the next CAS fall, RAS stays high for at least PRE_CYC cycles.
- R8: `we_n` is 1 in every cycle where `seq_drive` is 1.
- R9: The RAS bits of all banks are equal, and so are the CAS bits.
- R10: One refresh becomes owed on clock edges STARTUP_CYC + k·INTERVAL_CYC (k ≥ 1). At the sample right after such an edge `ref_req` is still 0 when nothing else is owed, and it is 1 one edge later.
- R11: The count of owed periodic refreshes saturates at MAX_PENDING. All owed refreshes run back to back while `ref_gnt` stays high, and `ref_req` falls once none remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Controller hands the strobes over; held for the whole burst |
| ref_req | output | 1 | Refresh work is owed and waiting for a grant |
| seq_drive | output | 1 | Sequencer currently owns RAS, CAS and WE |
| ras_n | output | BANKS | Row strobe per bank, low active |
| cas_n | output | BANKS | Column strobe per bank, low active |
| we_n | output | 1 | Write enable, low active; held high during refresh |
| ready | output | 1 | Initialization finished; normal accesses allowed |

## Verification
The assertions assume the controller keeps `ref_gnt` high from the moment it grants until the burst has ended. They also assume it never grants a refresh the block has not asked for.

The stimulus follows these rules. It raises the grant only while a request is pending, or holds it steadily high across initialization. It drops the grant only after the owed refreshes have drained.

Grant delays are placed relative to the known tick edges. This way each window holds a predictable number of owed refreshes, including a delay long enough to saturate the backlog.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_CASLEAD,
        ST_RASLOW,
        ST_PRECHG
    } cbr_state_e;

    typedef struct packed {
        logic drive;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    function automatic strobe_t strobe_for(cbr_state_e s);
        strobe_t r;
        r = '{drive: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        case (s)
            ST_CASLEAD: r = '{drive: 1'b1, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
            ST_RASLOW:  r = '{drive: 1'b1, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            ST_PRECHG:  r = '{drive: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            default:    r = '{drive: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return r;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ref_timer.sv
module ref_timer #(
    parameter int STARTUP_CYC  = 20000,
    parameter int INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst,
    output logic start_done,
    output logic tick
);
    localparam int SW = $clog2(STARTUP_CYC + 1);
    localparam int IW = $clog2(INTERVAL_CYC + 1);
    localparam logic [SW-1:0] S_LAST = SW'(STARTUP_CYC - 1);
    localparam logic [IW-1:0] I_LAST = IW'(INTERVAL_CYC - 1);

    logic [SW-1:0] st_cnt;
    logic [IW-1:0] iv_cnt;
    logic          running;

    assign start_done = !running && (st_cnt == S_LAST);
    assign tick       = running && (iv_cnt == I_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_cnt  <= '0;
            iv_cnt  <= '0;
            running <= 1'b0;
        end else if (!running) begin
            if (start_done) running <= 1'b1;
            else            st_cnt  <= st_cnt + 1'b1;
        end else begin
            iv_cnt <= tick ? '0 : iv_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
    parameter int INIT_REFRESHES = 8,
    parameter int MAX_PENDING    = 4,
    parameter int CW             = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_init,
    input  logic          tick,
    input  logic          take,
    output logic          avail,
    output logic [CW-1:0] pending
);
    localparam logic [CW-1:0] CAP  = CW'(MAX_PENDING);
    localparam logic [CW-1:0] INIT = CW'(INIT_REFRESHES);

    logic inc;
    assign inc   = tick && (pending < CAP);
    assign avail = (pending != '0);

    always_ff @(posedge clk) begin
        if (rst)            pending <= '0;
        else if (load_init) pending <= INIT;
        else if (inc && !take) pending <= pending + 1'b1;
        else if (!inc && take) pending <= pending - 1'b1;
    end
endmodule

// File: rtl/cbr_engine.sv
module cbr_engine
    import dram_ref_pkg::*;
#(
    parameter int CAS_LEAD_CYC = 1,
    parameter int RAS_LOW_CYC  = 6,
    parameter int PRE_CYC      = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    avail,
    input  logic    gnt,
    output logic    req,
    output logic    take,
    output logic    done,
    output strobe_t strb
);
    localparam int PW = $clog2(max2(max2(CAS_LEAD_CYC, RAS_LOW_CYC), PRE_CYC) + 1);
    localparam logic [PW-1:0] L_LEAD = PW'(CAS_LEAD_CYC - 1);
    localparam logic [PW-1:0] L_LOW  = PW'(RAS_LOW_CYC - 1);
    localparam logic [PW-1:0] L_PRE  = PW'(PRE_CYC - 1);

    cbr_state_e    st, st_nx;
    logic [PW-1:0] cnt;
    logic          phase_end;

    always_comb begin
        case (st)
            ST_CASLEAD: phase_end = (cnt == L_LEAD);
            ST_RASLOW:  phase_end = (cnt == L_LOW);
            ST_PRECHG:  phase_end = (cnt == L_PRE);
            default:    phase_end = 1'b0;
        endcase
    end

    always_comb begin
        st_nx = st;
        take  = 1'b0;
        done  = 1'b0;
        case (st)
            ST_IDLE: if (avail) st_nx = ST_REQ;
            ST_REQ: if (gnt) begin
                st_nx = ST_CASLEAD;
                take  = 1'b1;
            end
            ST_CASLEAD: if (phase_end) st_nx = ST_RASLOW;
            ST_RASLOW:  if (phase_end) st_nx = ST_PRECHG;
            ST_PRECHG: if (phase_end) begin
                done = 1'b1;
                if (avail && gnt) begin
                    st_nx = ST_CASLEAD;
                    take  = 1'b1;
                end else if (avail) begin
                    st_nx = ST_REQ;
                end else begin
                    st_nx = ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= (st_nx != st || phase_end) ? '0 : cnt + 1'b1;
        end
    end

    assign req  = (st == ST_REQ);
    assign strb = strobe_for(st);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_ref_pkg::*;
#(
    parameter int BANKS          = 2,
    parameter int STARTUP_CYC    = 20000,
    parameter int INTERVAL_CYC   = 1560,
    parameter int INIT_REFRESHES = 8,
    parameter int MAX_PENDING    = 4,
    parameter int CAS_LEAD_CYC   = 1,
    parameter int RAS_LOW_CYC    = 6,
    parameter int PRE_CYC        = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             seq_drive,
    output logic [BANKS-1:0] ras_n,
    output logic [BANKS-1:0] cas_n,
    output logic             we_n,
    output logic             ready
);
    localparam int CW = $clog2(max2(INIT_REFRESHES, MAX_PENDING) + 1);
    localparam int NW = $clog2(INIT_REFRESHES + 1);
    localparam logic [NW-1:0] INIT_N = NW'(INIT_REFRESHES);

    logic          start_done, tick, take, done, avail;
    logic [CW-1:0] pending;
    logic [NW-1:0] init_left;
    strobe_t       strb;

    ref_timer #(.STARTUP_CYC(STARTUP_CYC), .INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk(clk), .rst(rst), .start_done(start_done), .tick(tick)
    );

    ref_backlog #(.INIT_REFRESHES(INIT_REFRESHES), .MAX_PENDING(MAX_PENDING), .CW(CW)) u_backlog (
        .clk(clk), .rst(rst), .load_init(start_done), .tick(tick), .take(take),
        .avail(avail), .pending(pending)
    );

    cbr_engine #(.CAS_LEAD_CYC(CAS_LEAD_CYC), .RAS_LOW_CYC(RAS_LOW_CYC), .PRE_CYC(PRE_CYC)) u_engine (
        .clk(clk), .rst(rst), .avail(avail), .gnt(ref_gnt),
        .req(ref_req), .take(take), .done(done), .strb(strb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            init_left <= INIT_N;
            ready     <= 1'b0;
        end else if (done && !ready) begin
            init_left <= init_left - 1'b1;
            if (init_left == NW'(1)) ready <= 1'b1;
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign ras_n[b] = strb.ras_n;
        assign cas_n[b] = strb.cas_n;
    end

    assign we_n      = strb.we_n;
    assign seq_drive = strb.drive;
endmodule

// File: rtl/ref_seq_checker.sv
module ref_seq_checker #(
    parameter int BANKS       = 2,
    parameter int CW          = 4,
    parameter int MAX_PENDING = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_gnt,
    input logic             ref_req,
    input logic             seq_drive,
    input logic [BANKS-1:0] ras_n,
    input logic [BANKS-1:0] cas_n,
    input logic             we_n,
    input logic             ready,
    input logic [CW-1:0]    pending
);
    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_gnt) |=> ref_req);

    p_no_drive_unasked_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_drive) |-> $past(ref_req && ref_gnt));

    p_cas_leads_ras_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n[0]) |-> ($past(!cas_n[0]) && !cas_n[0]));

    p_cas_rises_with_ras_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n[0]) |-> $rose(cas_n[0]));

    p_cas_after_precharge_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n[0]) |-> ($past(ras_n[0]) && ras_n[0]));

    p_we_high_r8: assert property (@(posedge clk) disable iff (rst)
        seq_drive |-> we_n);

    p_banks_equal_r9: assert property (@(posedge clk) disable iff (rst)
        (ras_n == {BANKS{ras_n[0]}}) && (cas_n == {BANKS{cas_n[0]}}));

    p_ready_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    p_backlog_cap_r11: assert property (@(posedge clk) disable iff (rst)
        ready |-> (pending <= CW'(MAX_PENDING)));
endmodule

bind dram_refresh_seq ref_seq_checker #(
    .BANKS(BANKS), .CW(CW), .MAX_PENDING(MAX_PENDING)
) u_chk (
    .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .seq_drive(seq_drive), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ready(ready), .pending(pending)
);

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
    localparam int CLK_PERIOD = 10;
    localparam int BANKS = 2;
    localparam int S   = 50;
    localparam int I   = 100;
    localparam int NI  = 8;
    localparam int MP  = 3;
    localparam int CL  = 2;
    localparam int RL  = 6;
    localparam int PR  = 4;
    localparam int NV  = 5;
    // grant delay after tick edge, window end offset, expected refresh count
    localparam int VEC [NV][3] = '{
        '{0,   90,  1},
        '{7,   90,  1},
        '{40,  95,  1},
        '{120, 190, 2},
        '{350, 395, 3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_gnt = 1'b0;
    logic ref_req, seq_drive, we_n, ready;
    logic [BANKS-1:0] ras_n, cas_n;

    int cyc = 0;
    int n_ref = 0;
    int total = 0;
    int fails = 0;
    int wd = 0;
    logic mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_seq #(
        .BANKS(BANKS), .STARTUP_CYC(S), .INTERVAL_CYC(I), .INIT_REFRESHES(NI),
        .MAX_PENDING(MP), .CAS_LEAD_CYC(CL), .RAS_LOW_CYC(RL), .PRE_CYC(PR)
    ) u0 (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .seq_drive(seq_drive), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ready(ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        if (!rst) cyc <= cyc + 1;
        wd <= wd + 1;
        if (wd > 20000) begin
            fails++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
            summary();
        end
    end

    // strobe-shape monitor
    logic p_ras = 1'b1, p_cas = 1'b1, seen_rise = 1'b0;
    int lead = 0, low = 0, gap = 0;
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            if (!cas_n[0] && ras_n[0]) lead++;
            if (!ras_n[0]) low++;
            if (ras_n[0] && seen_rise && p_ras) gap++;
            if (p_cas && !cas_n[0]) begin
                if (seen_rise) check(gap >= PR, "R7 precharge", gap, PR);
                check(we_n == 1'b1, "R8 we high", int'(we_n), 1);
            end
            if (p_ras && !ras_n[0]) begin
                n_ref++;
                check(lead == CL, "R5 cas lead", lead, CL);
                check(ras_n == {BANKS{1'b0}} && cas_n == {BANKS{1'b0}}, "R9 banks equal",
                      int'({ras_n, cas_n}), 0);
                lead = 0;
            end
            if (!p_ras && ras_n[0]) begin
                check(low == RL, "R6 ras low", low, RL);
                check(cas_n[0] == 1'b1, "R6 cas rises with ras", int'(cas_n[0]), 1);
                low = 0;
                gap = 1;
                seen_rise = 1'b1;
            end
            if (seq_drive && !we_n) check(1'b0, "R8 we low while driving", 0, 1);
            p_ras = ras_n[0];
            p_cas = cas_n[0];
        end
    end

    task automatic wait_cyc(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    initial begin
        int t;
        int base;
        bit quiet;
        repeat (4) @(negedge clk);
        check(!ref_req && !ready && !seq_drive && ras_n == '1 && cas_n == '1,
              "R1 reset state", int'({ref_req, ready, seq_drive}), 0);
        rst = 1'b0;
        ref_gnt = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        check(!ref_req && !ready && !seq_drive && ras_n == '1 && cas_n == '1,
              "R1 first cycle idle", int'({ref_req, ready, seq_drive}), 0);
        quiet = 1'b1;
        while (cyc != S) begin
            if (ref_req) quiet = 1'b0;
            @(negedge clk);
        end
        check(quiet && !ref_req, "R2 no request during start-up", int'(ref_req), 0);
        @(negedge clk);
        check(ref_req == 1'b1, "R2 request after start-up", int'(ref_req), 1);
        while (!ready && cyc < S + 400) @(negedge clk);
        check(ready == 1'b1, "R3 ready reached", int'(ready), 1);
        check(n_ref == NI, "R3 init refresh count", n_ref, NI);
        wait_cyc(S + I + 30);
        ref_gnt = 1'b0;
        check(ready == 1'b1, "R3 ready sticky", int'(ready), 1);

        for (int v = 0; v < NV; v++) begin
            t = S + ((cyc - S) / I + 1) * I;
            wait_cyc(t);
            base = n_ref;
            check(ref_req == 1'b0, "R10 request one edge after tick", int'(ref_req), 0);
            if (VEC[v][0] > 0) begin
                wait_cyc(t + 1);
                check(ref_req == 1'b1, "R10 request after tick", int'(ref_req), 1);
                check(seq_drive == 1'b0, "R4 no drive before grant", int'(seq_drive), 0);
                wait_cyc(t + VEC[v][0]);
                check(ref_req == 1'b1 && ras_n == '1 && cas_n == '1,
                      "R4 request held without grant", int'(ref_req), 1);
            end
            ref_gnt = 1'b1;
            wait_cyc(t + VEC[v][1]);
            ref_gnt = 1'b0;
            check(n_ref - base == VEC[v][2], "R11 refreshes in window", n_ref - base, VEC[v][2]);
            check(ref_req == 1'b0, "R11 request drops when drained", int'(ref_req), 0);
        end

        // directed: reset in the middle of a refresh
        t = S + ((cyc - S) / I + 1) * I;
        ref_gnt = 1'b1;
        wait_cyc(t + 5);
        check(seq_drive == 1'b1, "R4 driving after grant", int'(seq_drive), 1);
        mon_on = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(!ref_req && !ready && !seq_drive && ras_n == '1 && cas_n == '1,
              "R1 reset mid-refresh", int'({ref_req, ready, seq_drive}), 0);
        summary();
    end
endmodule